// File: doc/BRIEF.md
# ADC master serial readout controller

This block is the digital half of a successive-approximation converter's master serial port. A rising edge on the start input opens a conversion. The conversion holds the busy flag high for a fixed number of clock cycles and ends by capturing a 16-bit word from a parallel input. The block makes its own serial clock by dividing the system clock. It drives a frame line and a serial data line so that a host can shift the word in, most significant bit first.

A mode input picks one of two readout timings. In read-after mode, the freshly captured word is shifted out once its conversion ends, and busy stays high until the last bit has left. In read-during mode, the word from the previous conversion is shifted out while the new conversion runs, and busy falls when the conversion ends. The serial clock and the frame line each have their own polarity-invert input. The data line and clock toggling are allowed only while both chip select and read are low and the block is in master mode. Otherwise the transfer pauses in place.

Top module: `sar_serial_master`

## Requirements
- R1: When `clk_sel_ext` is 1, the block is not in master mode. `sdata` is 0, `sclk` sits at its idle level and `frame` is inactive. Any running transfer pauses and resumes when `clk_sel_ext` returns to 0.
- R2: A start is the first cycle with `conv_start` at 1 after a cycle with it at 0, while the block is idle (busy low and no transfer running). `busy` rises after that clock edge. The conversion lasts `CONV_CYCLES` cycles and then captures `par_data`.
- R3: Each word is 16 bits long, D15 first and D0 last. Data changes only when the internal serial clock falls, so each bit is stable at the rising edge. The frame is active for exactly 16*`SCLK_DIV` enabled cycles per word.
- R4: The `sclk` pin equals the internal clock XOR `inv_sclk`, and the internal clock is 0 at idle. The `frame` pin equals the active-high frame XOR `inv_frame`. With both controls at 1, the idle pin levels are 1.
- R5: With `read_mode` = 0 at the start, the word captured by that conversion is shifted out right after the conversion ends.
- R6: In read-after mode, `busy` falls together with the end of the 16th bit. With the transfer enabled throughout, busy lasts `CONV_CYCLES` + 16*`SCLK_DIV` cycles.
- R7: With `read_mode` = 1 at the start, the previously captured word is shifted out from the start onward, and `busy` falls at the end of the conversion after exactly `CONV_CYCLES` cycles.
- R8: After reset, the stored previous word is 0, so the first read-during transfer returns 0x0000.
- R9: A start edge while busy is high, or while a transfer is still running, is ignored. The conversion is not restarted, no extra word is produced and busy does not rise again.
- R10: While `cs_n` or `rd_n` is 1, `sdata` is 0 and `sclk` stays at its idle level. The transfer pauses, so in read-after mode busy is lengthened by the paused cycles.
- R11: The internal serial clock period is `SCLK_DIV` enabled cycles, so consecutive rising edges within a frame are `SCLK_DIV` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Conversion start request, acted on at its rising edge |
| read_mode | input | 1 | 0: read after conversion, 1: read previous word during conversion |
| clk_sel_ext | input | 1 | Clock source select; 0 selects master operation |
| inv_sclk | input | 1 | Inverts the serial clock pin |
| inv_frame | input | 1 | Inverts the frame pin |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| par_data | input | 16 | Conversion result captured at the end of a conversion |
| busy | output | 1 | High while a conversion (and, in read-after mode, its transfer) is in progress |
| sclk | output | 1 | Generated serial clock |
| frame | output | 1 | Marks valid serial data |
| sdata | output | 1 | Serial data, MSB first |

## Verification
The checker watches several properties on every cycle. A conversion in progress always shows busy. The fall of busy coincides with the end of the transfer in read-after mode and with the end of the conversion in read-during mode. The clock, data and frame pins stay at their idle levels whenever the port is gated or in non-master mode. The bench scenarios are needed for the rest: bit order and word contents in both modes, the zero word after reset, the exact busy and frame lengths, serial clock spacing, the effect of inverted polarity, ignored start edges, and busy lengthening during a pause.

// File: rtl/sar_serial_master.sv
module sar_serial_master #(
  parameter int RES_W       = 16,
  parameter int CONV_CYCLES = 24,
  parameter int SCLK_DIV    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             read_mode,
  input  logic             clk_sel_ext,
  input  logic             inv_sclk,
  input  logic             inv_frame,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic [RES_W-1:0] par_data,
  output logic             busy,
  output logic             sclk,
  output logic             frame,
  output logic             sdata
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int DW = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
  localparam int BW = $clog2(RES_W);

  logic             start_q, conv_on, xfer, mode_q;
  logic [CW-1:0]    conv_cnt;
  logic [DW-1:0]    div_cnt;
  logic [BW-1:0]    bit_cnt;
  logic [RES_W-1:0] last_res, shreg;

  wire en         = ~cs_n & ~rd_n & ~clk_sel_ext;
  wire start_edge = conv_start & ~start_q;
  wire idle       = ~busy & ~xfer;
  wire conv_end   = conv_on && (conv_cnt == CW'(CONV_CYCLES - 1));
  wire bit_end    = xfer && en && (div_cnt == DW'(SCLK_DIV - 1));
  wire last_bit   = bit_end && (bit_cnt == BW'(RES_W - 1));
  wire sclk_int   = div_cnt >= DW'(SCLK_DIV / 2);
  wire live       = xfer & en;

  assign sclk  = (live & sclk_int) ^ inv_sclk;
  assign frame = live ^ inv_frame;
  assign sdata = live & shreg[RES_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      conv_on  <= 1'b0;
      xfer     <= 1'b0;
      mode_q   <= 1'b0;
      busy     <= 1'b0;
      conv_cnt <= '0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      last_res <= '0;
      shreg    <= '0;
    end else begin
      start_q <= conv_start;
      if (start_edge && idle) begin
        busy     <= 1'b1;
        conv_on  <= 1'b1;
        conv_cnt <= '0;
        mode_q   <= read_mode;
        if (read_mode) begin
          xfer    <= 1'b1;
          shreg   <= last_res;
          bit_cnt <= '0;
          div_cnt <= '0;
        end
      end else begin
        if (conv_on) begin
          if (conv_end) begin
            conv_on  <= 1'b0;
            last_res <= par_data;
            if (mode_q) begin
              busy <= 1'b0;
            end else begin
              xfer    <= 1'b1;
              shreg   <= par_data;
              bit_cnt <= '0;
              div_cnt <= '0;
            end
          end else begin
            conv_cnt <= conv_cnt + 1'b1;
          end
        end
        if (live) begin
          if (bit_end) begin
            div_cnt <= '0;
            if (last_bit) begin
              xfer <= 1'b0;
              if (!mode_q) busy <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              shreg   <= {shreg[RES_W-2:0], 1'b0};
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sar_serial_master_chk.sv
module sar_serial_master_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_sel_ext,
  input logic inv_sclk,
  input logic inv_frame,
  input logic cs_n,
  input logic rd_n,
  input logic busy,
  input logic sclk,
  input logic frame,
  input logic sdata,
  input logic xfer,
  input logic conv_on,
  input logic mode_q
);
  // R2
  conv_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_on |-> busy);

  // R6
  after_busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !mode_q) |-> $fell(xfer));

  // R7
  during_busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && mode_q) |-> $fell(conv_on));

  // R10
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (sclk == inv_sclk && sdata == 1'b0));

  // R1
  ext_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_ext |-> (frame == inv_frame && sdata == 1'b0 && sclk == inv_sclk));

  // R4
  frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |-> (frame == inv_frame));
endmodule

bind sar_serial_master sar_serial_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel_ext(clk_sel_ext), .inv_sclk(inv_sclk),
  .inv_frame(inv_frame), .cs_n(cs_n), .rd_n(rd_n), .busy(busy), .sclk(sclk),
  .frame(frame), .sdata(sdata), .xfer(xfer), .conv_on(conv_on), .mode_q(mode_q)
);

// File: tb/sim_sar_serial_master.sv
module sim_sar_serial_master;
  localparam int W = 16, CONV = 24, DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_start = 1'b0, read_mode = 1'b0, clk_sel_ext = 1'b0;
  logic inv_sclk = 1'b0, inv_frame = 1'b0, cs_n = 1'b0, rd_n = 1'b0;
  logic [W-1:0] par_data = '0;
  logic busy, sclk, frame, sdata;

  sar_serial_master #(.RES_W(W), .CONV_CYCLES(CONV), .SCLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .read_mode(read_mode),
    .clk_sel_ext(clk_sel_ext), .inv_sclk(inv_sclk), .inv_frame(inv_frame),
    .cs_n(cs_n), .rd_n(rd_n), .par_data(par_data), .busy(busy), .sclk(sclk),
    .frame(frame), .sdata(sdata));

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] word = '0, prev_tb = '0;
  int nb = 0, gap = 0, gap_bad = 0, fa_total = 0, rises = 0;
  int bcnt = 0, last_busy = 0;
  logic busy_prev = 1'b0, sc_prev = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic fa, sc;
      fa = frame ^ inv_frame;
      sc = sclk ^ inv_sclk;
      if (busy && !busy_prev) rises++;
      busy_prev = busy;
      if (busy) bcnt++;
      else if (bcnt != 0) begin last_busy = bcnt; bcnt = 0; end
      if (fa) begin
        fa_total++;
        gap++;
        if (sc && !sc_prev) begin
          if (nb > 0 && gap != DIV) gap_bad++;
          gap = 0;
          word = {word[W-2:0], sdata};
          nb++;
          if (nb == W) begin
            nb = 0;
            if (exp_q.size() == 0) check(1'b0, "R9 unexpected word", word, 0);
            else begin
              logic [W-1:0] e;
              string t;
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              check(word == e, t, word, e);
            end
          end
        end
        sc_prev = sc;
      end
    end
  end

  task automatic push(input logic [W-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic pulse_start();
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy || (frame ^ inv_frame)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic convert(input bit mode, input logic [W-1:0] d, input string t);
    read_mode = mode;
    par_data  = d;
    push(mode ? prev_tb : d, t);
    prev_tb = d;
    pulse_start();
  endtask

  initial begin
    int fa0, r0;
    repeat (3) @(negedge clk);
    check(busy == 0 && sdata == 0, "R2 reset busy/sdata", {busy, sdata}, 0);
    check(sclk == 0 && frame == 0, "R4 reset idle pins", {sclk, frame}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 / R7: first read-during returns zero, busy lasts CONV
    fa0 = fa_total;
    convert(1'b1, 16'h1234, "R8 first previous word");
    wait_idle();
    check(last_busy == CONV, "R7 busy width", last_busy, CONV);
    check(fa_total - fa0 == W*DIV, "R3 frame length", fa_total - fa0, W*DIV);

    convert(1'b1, 16'h8001, "R7 previous word");
    wait_idle();

    // R5 / R6: read-after
    fa0 = fa_total; r0 = rises;
    convert(1'b0, 16'hA5C3, "R5 new word");
    wait_idle();
    check(last_busy == CONV + W*DIV, "R6 busy width", last_busy, CONV + W*DIV);
    check(fa_total - fa0 == W*DIV, "R3 frame length after", fa_total - fa0, W*DIV);
    check(rises - r0 == 1, "R2 single busy pulse", rises - r0, 1);

    // R9: start during busy
    r0 = rises;
    convert(1'b0, 16'h3C5A, "R9 word with repeated start");
    repeat (4) @(negedge clk);
    pulse_start();
    wait_idle();
    check(last_busy == CONV + W*DIV, "R9 busy not restarted", last_busy, CONV + W*DIV);
    check(rises - r0 == 1, "R9 no extra busy", rises - r0, 1);

    // R9: start during read-during transfer after busy fell
    r0 = rises; fa0 = fa_total;
    convert(1'b1, 16'h7E81, "R9 read-during word");
    repeat (CONV + 8) @(negedge clk);
    check(busy == 0, "R7 busy low while transfer runs", busy, 0);
    pulse_start();
    wait_idle();
    check(rises - r0 == 1, "R9 start during transfer ignored", rises - r0, 1);
    check(fa_total - fa0 == W*DIV, "R9 single frame", fa_total - fa0, W*DIV);

    // R4: inverted polarity
    inv_sclk = 1'b1; inv_frame = 1'b1;
    @(negedge clk);
    check(sclk == 1 && frame == 1, "R4 inverted idle", {sclk, frame}, 3);
    convert(1'b0, 16'hF00F, "R4 inverted transfer");
    wait_idle();
    inv_sclk = 1'b0; inv_frame = 1'b0;

    // R10: pause by chip select
    convert(1'b0, 16'h0FF0, "R10 paused word");
    repeat (CONV + 10) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    check(sclk == 0 && sdata == 0 && busy == 1, "R10 gated pins", {sclk, sdata, busy}, 1);
    repeat (19) @(negedge clk);
    cs_n = 1'b0;
    wait_idle();
    check(last_busy == CONV + W*DIV + 20, "R10 busy lengthened", last_busy, CONV + W*DIV + 20);

    // R1: non-master select pauses
    convert(1'b0, 16'hC001, "R1 resumed word");
    repeat (CONV + 30) @(negedge clk);
    clk_sel_ext = 1'b1;
    @(negedge clk);
    check(frame == 0 && sclk == 0 && sdata == 0, "R1 non-master idle", {frame, sclk, sdata}, 0);
    repeat (7) @(negedge clk);
    clk_sel_ext = 1'b0;
    wait_idle();
    check(last_busy == CONV + W*DIV + 8, "R1 busy with pause", last_busy, CONV + W*DIV + 8);

    check(gap_bad == 0, "R11 sclk period", gap_bad, 0);
    check(exp_q.size() == 0, "R3 all words seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule